// File: doc/BRIEF.md
# Counter-Difference Quadrature Decimator

This block turns a stream of 32-bit running-counter snapshots into 8-bit offset-binary I/Q sample pairs. Each group of eight snapshot words yields one pair, a decimation by four. From each group it forms four signed differences. It passes them through a single real FIR filter whose taps are sliding four-term sums of a six-entry base coefficient set. Even tap positions feed the Q accumulator and odd positions feed the I accumulator, so one filter and an 11-entry history give both quadrature outputs without a separate mixer.

Each accumulator is scaled by an unsigned gain and divided by 128. A DC offset of 181/256 of the maximum amplitude is then removed, and the result is divided by that maximum amplitude. The quotient is clipped to the signed byte range and sent as an unsigned byte with 128 added. The surrounding control logic supplies the gain and the maximum amplitude, and it groups the output pairs into blocks.

Top module: `cntdiff_iq_decim`

## Requirements
- R1: A word is taken on every rising clock edge where `in_valid` and `in_ready` are both high. Eight taken words b0..b7, in arrival order, form one group. Exactly one I/Q byte pair comes out per group.
- R2: The four differences are x3 = b0 − b1, x2 = b2 − b3, x1 = b5 − b4 and x0 = b7 − b6. Each is taken modulo 2^32 and read as a signed 32-bit value.
- R3: Let h0..h10 be the stored history values. The accumulators are Q = 4·h10 − 2·h8 + 4·h6 + 120·h4 + 120·h2 + 4·h0 − 2·x2 + 4·x0 and I = 6·h9 − 11·h7 + 57·h5 + 148·h3 + 57·h1 − 11·x3 + 6·x1.
- R4: After each group the history advances by four: h10..h4 take the old h6..h0, and h3, h2, h1, h0 take x3, x2, x1, x0. Reset clears every history entry to zero.
- R5: Each accumulator is multiplied by the unsigned `gain` value and then divided by 128, truncating toward zero.
- R6: The result then has floor(max_amp·181/256) subtracted and is divided by `max_amp`, truncating toward zero. `max_amp` must be nonzero.
- R7: The quotient is clamped to −128..127 and sent as that value plus 128. For example, 127 is sent as 255, −128 as 0 and 0 as 128.
- R8: A pair appears as two consecutive cycles with `out_valid` high. The I byte comes first with `out_q` = 0, and the Q byte follows with `out_q` = 1. `out_valid` is low in the cycle after the Q byte.
- R9: `in_ready` stays low from the edge that takes b7 until the cycle after the Q byte. `in_valid` and `in_data` in that window are ignored and are not counted as words of the next group.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Snapshot word present on `in_data` |
| in_ready | output | 1 | Block is gathering words |
| in_data | input | DATA_W (32) | Counter snapshot word |
| gain | input | GAIN_W (16) | Unsigned gain, 128 means ×1 |
| max_amp | input | AMP_W (32) | Normalising divisor, nonzero |
| out_valid | output | 1 | Output byte present |
| out_q | output | 1 | 0 for the I byte, 1 for the Q byte |
| out_data | output | 8 | Offset-binary sample byte |

## Verification
The checker assumes that `max_amp` is nonzero whenever a word is accepted. It also assumes that `gain` and `max_amp` hold steady from the eighth word of a group until that group's Q byte leaves. The stimulus changes both values only after all expected bytes of the earlier groups have been drained, and it never uses a divisor of zero. The stimulus holds `in_valid` high with junk data during the busy window, inserts idle gaps between words, and applies a reset in the middle of the run. Expected bytes come from a wide-integer model of the arithmetic that keeps its own copy of the history.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

   // Structure of one group: four differences made from eight words.
   localparam int DIFF_N         = 4;
   localparam int WORDS_PER_PAIR = 2 * DIFF_N;
   localparam int HIST_N         = 11;
   localparam int TAP_N          = HIST_N + DIFF_N;
   localparam int BASE_N         = 6;
   localparam int MIRROR_N       = 2 * BASE_N;

   // Arithmetic constants of the scaling stage.
   localparam int GAIN_SHIFT = 7;
   localparam int OFF_MUL    = 181;
   localparam int OFF_SHIFT  = 8;

   typedef enum logic [2:0] {
      ST_GATHER,
      ST_CALC,
      ST_LAUNCH_I,
      ST_WAIT_I,
      ST_LAUNCH_Q,
      ST_WAIT_Q,
      ST_EMIT_I,
      ST_EMIT_Q
   } cdf_state_e;

   function automatic int base_coef(input int k);
      case (k)
         0:       return 4;
         1:       return 2;
         2:       return -8;
         3:       return -9;
         4:       return 19;
         default: return 55;
      endcase
   endfunction

   // The base set followed by its reverse gives a symmetric response.
   function automatic int mirror_coef(input int m);
      if (m < 0 || m >= MIRROR_N) return 0;
      if (m < BASE_N) return base_coef(m);
      return base_coef(MIRROR_N - 1 - m);
   endfunction

   // Tap j is the sum of four neighbouring mirrored coefficients.
   function automatic int tap_weight(input int j);
      int acc;
      acc = 0;
      for (int m = j - (DIFF_N - 1); m <= j; m++) acc += mirror_coef(m);
      return acc;
   endfunction

   // Tap positions run from the oldest history entry to x0; even ones feed Q.
   function automatic bit tap_is_q(input int j);
      return (j % 2) == 0;
   endfunction

endpackage

// File: rtl/cdf_gather.sv
module cdf_gather #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         take,
   input  logic [DATA_W-1:0]            data,
   output logic [WORDS-1:0][DATA_W-1:0] words,
   output logic                         last
);
   localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   generate
      if (WORDS < 2) begin : g_bad_words
         $error("cdf_gather: WORDS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] slot_q;

   assign last = take && (slot_q == CNT_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (take) begin
         slot_q <= last ? '0 : slot_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
      end else if (take) begin
         words[slot_q] <= data;
      end
   end

endmodule

// File: rtl/cdf_qfir.sv
module cdf_qfir
   import cdf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 48
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  advance,
   input  logic [WORDS_PER_PAIR-1:0][DATA_W-1:0] words,
   output logic signed [ACC_W-1:0]               acc_i,
   output logic signed [ACC_W-1:0]               acc_q
);

   generate
      if (ACC_W < DATA_W + 10) begin : g_bad_acc
         $error("cdf_qfir: ACC_W too narrow for the tap gains");
      end
   endgenerate

   logic signed [DATA_W-1:0] diff_v [DIFF_N];
   logic signed [DATA_W-1:0] hist_q [HIST_N];
   logic signed [DATA_W-1:0] tap_v  [TAP_N];
   logic signed [ACC_W-1:0]  term_v [TAP_N];

   // Newest differences in order x3, x2, x1, x0; the second pair is reversed.
   assign diff_v[0] = $signed(words[0] - words[1]);
   assign diff_v[1] = $signed(words[2] - words[3]);
   assign diff_v[2] = $signed(words[5] - words[4]);
   assign diff_v[3] = $signed(words[7] - words[6]);

   // tap_v[0] is the oldest history entry, tap_v[TAP_N-1] is x0.
   generate
      for (genvar k = 0; k < HIST_N; k++) begin : g_hist_tap
         assign tap_v[k] = hist_q[k];
      end
      for (genvar k = 0; k < DIFF_N; k++) begin : g_new_tap
         assign tap_v[HIST_N + k] = diff_v[k];
      end
      for (genvar j = 0; j < TAP_N; j++) begin : g_term
         localparam int WEIGHT = tap_weight(j);
         assign term_v[j] = ACC_W'(tap_v[j]) * ACC_W'(WEIGHT);
      end
   endgenerate

   always_comb begin
      acc_i = '0;
      acc_q = '0;
      for (int j = 0; j < TAP_N; j++) begin
         if (tap_is_q(j)) acc_q = acc_q + term_v[j];
         else             acc_i = acc_i + term_v[j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < HIST_N; k++) hist_q[k] <= '0;
      end else if (advance) begin
         for (int k = 0; k < HIST_N; k++) hist_q[k] <= tap_v[k + DIFF_N];
      end
   end

endmodule

// File: rtl/cdf_scale.sv
module cdf_scale
   import cdf_pkg::*;
#(
   parameter int ACC_W  = 48,
   parameter int GAIN_W = 16,
   parameter int AMP_W  = 32,
   parameter int NUM_W  = 66
) (
   input  logic signed [ACC_W-1:0] acc,
   input  logic [GAIN_W-1:0]       gain,
   input  logic [AMP_W-1:0]        max_amp,
   output logic signed [NUM_W-1:0] num
);
   localparam int PROD_W = NUM_W - 1;
   localparam int X181_W = AMP_W + OFF_SHIFT;

   generate
      if (NUM_W < ACC_W + GAIN_W + 2 || NUM_W <= AMP_W + 1) begin : g_bad_num
         $error("cdf_scale: NUM_W too narrow");
      end
   endgenerate

   logic signed [PROD_W-1:0] acc_x;
   logic signed [PROD_W-1:0] gain_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] scaled;
   logic [X181_W-1:0]        amp_x181;
   logic [AMP_W-1:0]         offset;

   assign acc_x  = PROD_W'(acc);
   assign gain_x = $signed(PROD_W'(gain));
   assign prod   = acc_x * gain_x;

   // Bias negative products so the arithmetic shift truncates toward zero.
   assign scaled = (prod + (prod[PROD_W-1] ? PROD_W'((1 << GAIN_SHIFT) - 1)
                                           : PROD_W'(0))) >>> GAIN_SHIFT;

   assign amp_x181 = X181_W'(max_amp) * X181_W'(OFF_MUL);
   assign offset   = amp_x181[X181_W-1:OFF_SHIFT];

   assign num = NUM_W'(scaled) - $signed(NUM_W'(offset));

endmodule

// File: rtl/cdf_sdiv.sv
module cdf_sdiv #(
   parameter int NUM_W = 66,
   parameter int DEN_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0]        divisor,
   output logic                    busy,
   output logic                    done,
   output logic signed [NUM_W-1:0] quotient
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   generate
      if (NUM_W < 2 || DEN_W < 1) begin : g_bad_div
         $error("cdf_sdiv: widths out of range");
      end
   endgenerate

   logic [NUM_W-1:0] mag_q;
   logic [NUM_W-1:0] quo_q;
   logic [DEN_W-1:0] rem_q;
   logic [CNT_W-1:0] left_q;
   logic             neg_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = {rem_q, mag_q[NUM_W-1]};
   assign fits  = trial >= {1'b0, divisor};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         left_q <= '0;
         neg_q  <= 1'b0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            mag_q  <= dividend[NUM_W-1] ? NUM_W'(-dividend) : NUM_W'(dividend);
            neg_q  <= dividend[NUM_W-1];
            quo_q  <= '0;
            rem_q  <= '0;
            left_q <= CNT_W'(NUM_W);
            busy   <= 1'b1;
         end else if (busy) begin
            rem_q  <= fits ? DEN_W'(trial - {1'b0, divisor}) : DEN_W'(trial);
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            mag_q  <= {mag_q[NUM_W-2:0], 1'b0};
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // Magnitude division with the sign applied afterwards truncates toward zero.
   assign quotient = neg_q ? -$signed(quo_q) : $signed(quo_q);

endmodule

// File: rtl/cntdiff_iq_decim.sv
module cntdiff_iq_decim
   import cdf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int GAIN_W = 16,
   parameter int AMP_W  = 32,
   parameter int ACC_W  = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [GAIN_W-1:0] gain,
   input  logic [AMP_W-1:0]  max_amp,
   output logic              out_valid,
   output logic              out_q,
   output logic [7:0]        out_data
);
   localparam int NUM_W  = ACC_W + GAIN_W + 2;
   localparam int LANE_N = 2;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("cntdiff_iq_decim: DATA_W must be at least 2");
      end
      if (GAIN_W < 8) begin : g_bad_gain
         $error("cntdiff_iq_decim: GAIN_W must hold the unity value 128");
      end
      if (AMP_W < 1 || AMP_W + 1 >= NUM_W) begin : g_bad_amp
         $error("cntdiff_iq_decim: AMP_W out of range");
      end
   endgenerate

   localparam logic signed [NUM_W-1:0] SAT_HI = NUM_W'(127);
   localparam logic signed [NUM_W-1:0] SAT_LO = NUM_W'(-128);

   cdf_state_e state_q, state_d;

   logic                                  take;
   logic                                  last_word;
   logic [WORDS_PER_PAIR-1:0][DATA_W-1:0] words;
   logic signed [ACC_W-1:0]               acc_lane [LANE_N];
   logic signed [NUM_W-1:0]               num_lane [LANE_N];
   logic signed [NUM_W-1:0]               num_i_q, num_q_q;
   logic signed [NUM_W-1:0]               div_num, div_quot;
   logic                                  div_start, div_busy, div_done;
   logic [7:0]                            byte_i_q, byte_q_q;

   assign in_ready = (state_q == ST_GATHER);
   assign take     = in_valid && in_ready;

   cdf_gather #(
      .DATA_W (DATA_W),
      .WORDS  (WORDS_PER_PAIR)
   ) u_gather (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .data  (in_data),
      .words (words),
      .last  (last_word)
   );

   cdf_qfir #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) u_qfir (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (state_q == ST_CALC),
      .words   (words),
      .acc_i   (acc_lane[0]),
      .acc_q   (acc_lane[1])
   );

   // Lane 0 carries I, lane 1 carries Q.
   generate
      for (genvar l = 0; l < LANE_N; l++) begin : g_lane
         cdf_scale #(
            .ACC_W  (ACC_W),
            .GAIN_W (GAIN_W),
            .AMP_W  (AMP_W),
            .NUM_W  (NUM_W)
         ) u_scale (
            .acc     (acc_lane[l]),
            .gain    (gain),
            .max_amp (max_amp),
            .num     (num_lane[l])
         );
      end
   endgenerate

   assign div_start = (state_q == ST_LAUNCH_I) || (state_q == ST_LAUNCH_Q);
   assign div_num   = (state_q == ST_LAUNCH_Q) ? num_q_q : num_i_q;

   cdf_sdiv #(
      .NUM_W (NUM_W),
      .DEN_W (AMP_W)
   ) u_sdiv (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (div_num),
      .divisor  (max_amp),
      .busy     (div_busy),
      .done     (div_done),
      .quotient (div_quot)
   );

   function automatic logic [7:0] clip_to_byte(input logic signed [NUM_W-1:0] v);
      if (v > SAT_HI)      return 8'hFF;
      else if (v < SAT_LO) return 8'h00;
      else                 return v[7:0] ^ 8'h80;
   endfunction

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_GATHER:   if (last_word) state_d = ST_CALC;
         ST_CALC:     state_d = ST_LAUNCH_I;
         ST_LAUNCH_I: state_d = ST_WAIT_I;
         ST_WAIT_I:   if (div_done) state_d = ST_LAUNCH_Q;
         ST_LAUNCH_Q: state_d = ST_WAIT_Q;
         ST_WAIT_Q:   if (div_done) state_d = ST_EMIT_I;
         ST_EMIT_I:   state_d = ST_EMIT_Q;
         default:     state_d = ST_GATHER;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_GATHER;
         num_i_q  <= '0;
         num_q_q  <= '0;
         byte_i_q <= 8'h80;
         byte_q_q <= 8'h80;
      end else begin
         state_q <= state_d;
         if (state_q == ST_CALC) begin
            num_i_q <= num_lane[0];
            num_q_q <= num_lane[1];
         end
         if (state_q == ST_WAIT_I && div_done) byte_i_q <= clip_to_byte(div_quot);
         if (state_q == ST_WAIT_Q && div_done) byte_q_q <= clip_to_byte(div_quot);
      end
   end

   assign out_valid = (state_q == ST_EMIT_I) || (state_q == ST_EMIT_Q);
   assign out_q     = (state_q == ST_EMIT_Q);
   assign out_data  = out_q ? byte_q_q : byte_i_q;

endmodule

// File: rtl/cntdiff_iq_decim_checker.sv
module cntdiff_iq_decim_checker
   import cdf_pkg::*;
#(
   parameter int AMP_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_q,
   input logic             div_busy,
   input logic [AMP_W-1:0] max_amp
);
   localparam int CNT_W = $clog2(WORDS_PER_PAIR);

   logic [CNT_W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (in_valid && in_ready) seen_q <= seen_q + CNT_W'(1);
   end

   assert_frame_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (seen_q == '0));

   assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && seen_q == CNT_W'(WORDS_PER_PAIR - 1)) |=> !in_ready);

   assert_amp_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (max_amp != '0));

   assert_q_after_i_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_q) |=> (out_valid && out_q));

   assert_q_has_i_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_q) |-> $past(out_valid && !out_q));

   assert_pair_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_q) |=> (!out_valid && in_ready));

   assert_busy_gates_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !in_ready);

   assert_emit_gates_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

endmodule

bind cntdiff_iq_decim cntdiff_iq_decim_checker #(.AMP_W(AMP_W)) u_chk (.*);

// File: tb/cntdiff_iq_decim_test.sv
module cntdiff_iq_decim_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic [15:0] gain = 16'd127;
   logic [31:0] max_amp = 32'd1500;
   logic        out_valid;
   logic        out_q;
   logic [7:0]  out_data;

   int n_checks = 0;
   int n_fail   = 0;

   logic [8:0] exp_q[$];
   string      tag_q[$];
   longint     hist_m [11];
   longint     wt [15] = '{4, 6, -2, -11, 4, 57, 120, 148, 120, 57, 4, -11, -2, 6, 4};

   always #(CLK_PERIOD/2) clk = ~clk;

   cntdiff_iq_decim uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .gain      (gain),
      .max_amp   (max_amp),
      .out_valid (out_valid),
      .out_q     (out_q),
      .out_data  (out_data)
   );

   task automatic check(input string tag, input bit ok, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] squash(input longint acc);
      longint p;
      longint m;
      m = longint'(max_amp);
      p = acc * longint'(gain);
      p = p / 128;
      p = p - (m * 181) / 256;
      p = p / m;
      if (p > 127) p = 127;
      if (p < -128) p = -128;
      return 8'(p + 128);
   endfunction

   function automatic void make_frame(input logic [31:0] base, input int d3, input int d2,
                                      input int d1, input int d0, output logic [31:0] w [8]);
      w[0] = base + 32'(d3);  w[1] = base;
      w[2] = base + 32'(d2);  w[3] = base;
      w[4] = base;            w[5] = base + 32'(d1);
      w[6] = base;            w[7] = base + 32'(d0);
   endfunction

   task automatic push_expect(input logic [31:0] w [8], input string tag);
      longint s [15];
      longint ai = 0;
      longint aq = 0;
      for (int k = 0; k < 11; k++) s[k] = hist_m[10 - k];
      s[11] = longint'($signed(w[0] - w[1]));
      s[12] = longint'($signed(w[2] - w[3]));
      s[13] = longint'($signed(w[5] - w[4]));
      s[14] = longint'($signed(w[7] - w[6]));
      for (int j = 0; j < 15; j++) begin
         if (j % 2 == 0) aq += wt[j] * s[j];
         else            ai += wt[j] * s[j];
      end
      exp_q.push_back({1'b0, squash(ai)}); tag_q.push_back({tag, " I"});
      exp_q.push_back({1'b1, squash(aq)}); tag_q.push_back({tag, " Q"});
      for (int i = 10; i >= 4; i--) hist_m[i] = hist_m[i - 4];
      hist_m[3] = s[11]; hist_m[2] = s[12]; hist_m[1] = s[13]; hist_m[0] = s[14];
   endtask

   task automatic send_frame(input logic [31:0] w [8], input string tag,
                             input int gap_mod, input bit junk);
      push_expect(w, tag);
      for (int k = 0; k < 8; k++) begin
         if (gap_mod > 0 && (k % gap_mod) == 1) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = w[k];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      check("R9 ready low after eighth word", in_ready == 1'b0, in_ready, 0);
      if (junk) begin
         in_data = 32'hDEAD_BEEF;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check("R9 ready low while busy", in_ready == 1'b0, in_ready, 0);
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic rand_frames(input int count, input int span, input string tag, input int gap_mod);
      logic [31:0] w [8];
      for (int f = 0; f < count; f++) begin
         make_frame($urandom(),
                    int'($urandom_range(2 * span)) - span, int'($urandom_range(2 * span)) - span,
                    int'($urandom_range(2 * span)) - span, int'($urandom_range(2 * span)) - span, w);
         send_frame(w, tag, gap_mod, 1'b0);
      end
   endtask

   // Scoreboard monitor: compares each output byte against the next expected one.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected output byte", 1'b0, {out_q, out_data}, -1);
         end else begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {out_q, out_data} == e, longint'({out_q, out_data}), longint'(e));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] w [8];
      for (int i = 0; i < 11; i++) hist_m[i] = 0;

      repeat (3) @(negedge clk);
      check("R10 out_valid low in reset", out_valid == 1'b0, out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 out_valid low after reset", out_valid == 1'b0, out_valid, 0);
      check("R10 in_ready high after reset", in_ready == 1'b1, in_ready, 1);

      // R3 zero history, then R4 history build-up
      make_frame(32'd1000, 100, -50, 30, 7, w);
      send_frame(w, "R3 first group", 0, 1'b0);
      make_frame(32'd5000, -40, 80, -120, 60, w);
      send_frame(w, "R4 history shift", 0, 1'b0);
      rand_frames(8, 500, "R3 random", 0);

      // R2 wrap-around differences
      make_frame(32'hFFFF_FFFE, 5, -3, 9, 1, w);
      send_frame(w, "R2 wrap", 0, 1'b0);
      make_frame(32'h0000_0002, -7, 4, -6, 3, w);
      send_frame(w, "R2 wrap negative", 0, 1'b0);

      // R1 gaps between words, R9 junk while busy
      rand_frames(4, 500, "R1 gapped", 2);
      make_frame(32'd77, 200, -100, 300, -50, w);
      send_frame(w, "R9 junk held", 0, 1'b1);
      rand_frames(2, 500, "R9 after junk", 0);
      drain();

      // R7 saturation
      max_amp = 32'd100;
      make_frame(32'd12345, -20000, 20000, -20000, 20000, w);
      send_frame(w, "R7 saturate", 0, 1'b0);
      make_frame(32'd12345, 20000, -20000, 20000, -20000, w);
      send_frame(w, "R7 saturate other", 0, 1'b0);
      drain();

      // R5 gain values
      max_amp = 32'd1500;
      gain = 16'd0;
      rand_frames(2, 500, "R5 gain zero", 0);
      drain();
      gain = 16'd1000;
      rand_frames(3, 200, "R5 gain large", 0);
      drain();
      gain = 16'd65535;
      rand_frames(2, 20, "R5 gain max", 0);
      drain();

      // R6 normalisation divisors
      gain = 16'd127;
      max_amp = 32'd1;
      rand_frames(2, 3, "R6 amp one", 0);
      drain();
      max_amp = 32'd3000;
      rand_frames(3, 1500, "R6 amp 3000", 0);
      drain();
      max_amp = 32'd65535;
      rand_frames(2, 40000, "R6 amp wide", 0);
      drain();

      // R4 and R10: reset clears the history
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 out_valid low in second reset", out_valid == 1'b0, out_valid, 0);
      for (int i = 0; i < 11; i++) hist_m[i] = 0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 in_ready high after second reset", in_ready == 1'b1, in_ready, 1);
      max_amp = 32'd1500;
      make_frame(32'd4242, 300, -250, 175, -90, w);
      send_frame(w, "R4 history cleared", 0, 1'b0);
      rand_frames(2, 500, "R8 order", 0);
      drain();

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule